// File: doc/BRIEF.md
# Slice-Serial Wide Adder/Subtractor

This block adds or subtracts two wide binary words using one narrow adder. The word is cut into slices of a parameterised step width. One slice is handled per enabled clock cycle, least-significant slice first, and each slice's carry feeds the next. This trades latency for a short carry chain and a small adder. When the word width is not a whole multiple of the step width, the last slice is only partly used: the operands are zero-padded above the word.

A valid/ready handshake brings in the operands and the operation select. Once an operation is accepted, the input side stays closed until the consumer has taken the result through the output valid/ready handshake. The result is held steady while it waits. The outputs are the sum, the unsigned carry-out, the carry into every bit of the sum, and a signed overflow flag. A clock enable freezes the block. A synchronous clear returns it to idle.

Top module: `slice_addsub`

## Requirements
- R1: With `op_sub`=0 the accepted result has `sum` = (a+b) mod 2^W and `cout` equal to the carry out of bit W-1.
- R2: With `op_sub`=1 the result has `sum` = (a-b) mod 2^W, formed as a + ~b + 1, and `cout`=1 exactly when a >= b as unsigned values.
- R3: `out_valid` rises after the NS-th enabled clock edge that follows the accepting edge, where NS = ceil(W/STEP). `in_ready` is low from the accepting edge until the output handshake completes.
- R4: While `out_valid`=1 and `out_ready`=0, `out_valid`, `sum`, `cout`, `carries` and `ovf` keep their values.
- R5: `carries[i]` is the carry into bit i of the sum, so `carries[0]` equals `op_sub`.
- R6: `ovf`=1 exactly when the two's-complement result of a±b falls outside the signed W-bit range.
- R7: While `ce`=0 no state changes. Each disabled cycle lengthens the latency by one cycle, and a pending output handshake is not taken.
- R8: `clr`=1 at a clock edge returns the block to idle (`in_ready`=1, `out_valid`=0) whatever `ce` is, and it drops any operation in progress.
- R9: Correct results are produced when W is not a multiple of STEP (default W=20, STEP=8, so the last slice carries 4 live bits), including carries that cross slice boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ce | input | 1 | Clock enable; low freezes all state |
| clr | input | 1 | Synchronous clear to idle |
| in_valid | input | 1 | Operands and op select are offered |
| in_ready | output | 1 | Block is idle and will accept |
| op_sub | input | 1 | 0 = a+b, 1 = a-b |
| a | input | W | First operand |
| b | input | W | Second operand |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| sum | output | W | Result word |
| cout | output | 1 | Carry out of the top bit (unsigned overflow / no-borrow) |
| carries | output | W | Carry into each bit of the sum |
| ovf | output | 1 | Signed overflow |

## Verification
Two conditions are hard to reach from the ports. The first is a carry that must ripple from the lowest slice through a full middle slice into the partial top slice. The stimulus creates it with operands such as 0x0FFFF+1 and 0xFFFFF+1, and with subtractions that borrow across all slices. The second is a clock-enable stall that lands in the middle of the slice sequence and again while a result waits. The bench drops `ce` after acceptance and counts only enabled edges when it checks latency. It also pulses `clr` with `ce` low while an operation is in progress, then confirms that no result ever appears.

// File: rtl/slice_addsub.sv
module slice_addsub #(
  parameter int W    = 20,
  parameter int STEP = 8
) (
  input  logic         clk,
  input  logic         ce,
  input  logic         clr,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         op_sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic [W-1:0] carries,
  output logic         ovf
);
  localparam int NS = (W + STEP - 1) / STEP;
  localparam int PW = NS * STEP;
  localparam int IW = (NS > 1) ? $clog2(NS) : 1;

  typedef enum logic [1:0] {IDLE, RUN, DONE} st_t;
  st_t st;

  logic [PW-1:0]   a_r, b_r, s_r;
  logic            c_r;
  logic [IW-1:0]   idx;
  logic [STEP:0]   sl;
  logic [PW-1:0]   cv;
  logic [PW:0]     ext;
  logic [W-1:0]    bn;

  assign bn  = op_sub ? ~b : b;
  assign sl  = {1'b0, a_r[idx*STEP +: STEP]} + {1'b0, b_r[idx*STEP +: STEP]} + {{STEP{1'b0}}, c_r};
  assign cv  = a_r ^ b_r ^ s_r;
  assign ext = {c_r, s_r};

  assign in_ready  = (st == IDLE);
  assign out_valid = (st == DONE);
  assign sum       = s_r[W-1:0];
  assign carries   = cv[W-1:0];
  assign cout      = ext[W];
  assign ovf       = cv[W-1] ^ cout;

  always_ff @(posedge clk) begin
    if (clr) begin
      st  <= IDLE;
      idx <= '0;
    end else if (ce) begin
      case (st)
        IDLE: if (in_valid) begin
          a_r <= PW'(a);
          b_r <= PW'(bn);
          s_r <= '0;
          c_r <= op_sub;
          idx <= '0;
          st  <= RUN;
        end
        RUN: begin
          s_r[idx*STEP +: STEP] <= sl[STEP-1:0];
          c_r <= sl[STEP];
          if (idx == IW'(NS - 1)) st <= DONE;
          else idx <= idx + 1'b1;
        end
        DONE: if (out_ready) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (clr)
    in_valid && in_ready && ce |=> !in_ready && !out_valid); // R3
  AST_RELEASE_OPENS: assert property (@(posedge clk) disable iff (clr)
    out_valid && out_ready && ce |=> in_ready); // R3
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (clr)
    out_valid && !out_ready |=> out_valid && $stable(sum) && $stable(cout) && $stable(carries)); // R4
  AST_FREEZE: assert property (@(posedge clk) disable iff (clr)
    !ce |=> $stable(in_ready) && $stable(out_valid) && $stable(sum)); // R7
  AST_CLEAR_IDLE: assert property (@(posedge clk)
    clr |=> in_ready && !out_valid); // R8
  AST_OVF_SIGN: assert property (@(posedge clk) disable iff (clr)
    out_valid |-> ovf == ((a_r[W-1] == b_r[W-1]) && (s_r[W-1] != a_r[W-1]))); // R6
endmodule

// File: tb/test_slice_addsub.sv
module test_slice_addsub;
  localparam int W = 20, STEP = 8, NS = (W + STEP - 1) / STEP;

  logic clk = 0, ce = 1, clr = 1, in_valid = 0, op_sub = 0, out_ready = 0;
  logic [W-1:0] a = '0, b = '0;
  logic in_ready, out_valid, cout, ovf;
  logic [W-1:0] sum, carries;

  slice_addsub #(.W(W), .STEP(STEP)) i_slice_addsub (
    .clk(clk), .ce(ce), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .op_sub(op_sub), .a(a), .b(b), .out_valid(out_valid), .out_ready(out_ready),
    .sum(sum), .cout(cout), .carries(carries), .ovf(ovf));

  always #4 clk = ~clk;

  typedef struct { logic [W-1:0] s; logic c; logic [W-1:0] cy; logic v; int acc; } exp_t;
  exp_t q[$];
  int n_cmp = 0, n_bad = 0, ce_cnt = 0, cyc = 0, bp = 0, rr = 0;
  bit first = 1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ce) ce_cnt <= ce_cnt + 1;
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(logic [W-1:0] x, logic [W-1:0] y, logic s);
    exp_t e;
    logic [W-1:0] yy = s ? ~y : y;
    logic [W:0] f = {1'b0, x} + {1'b0, yy} + (W+1)'(s);
    longint r = s ? (longint'($signed(x)) - longint'($signed(y)))
                  : (longint'($signed(x)) + longint'($signed(y)));
    e.s = f[W-1:0];
    e.c = f[W];
    for (int i = 0; i < W; i++) begin
      logic [W:0] m = ((W+1)'(1) << i) - 1'b1;
      logic [W:0] p = ({1'b0, x} & m) + ({1'b0, yy} & m) + (W+1)'(s);
      e.cy[i] = p[i];
    end
    e.v = (r > (longint'(1) <<< (W-1)) - 1) || (r < -(longint'(1) <<< (W-1)));
    e.acc = 0;
    return e;
  endfunction

  task automatic send(logic [W-1:0] x, logic [W-1:0] y, logic s);
    exp_t e = model(x, y, s);
    @(negedge clk);
    a = x; b = y; op_sub = s; in_valid = 1;
    while (!in_ready) @(negedge clk);
    e.acc = ce_cnt;
    q.push_back(e);
    @(negedge clk);
    in_valid = 0;
    chk(in_ready == 0, "R3 in_ready after accept", in_ready, 0);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (out_valid && q.size() == 0)
        chk(0, "R8 result with nothing pending", 1, 0);
      else if (out_valid) begin
        if (first) begin
          chk(ce_cnt - q[0].acc == NS + 1, "R3 latency", ce_cnt - q[0].acc, NS + 1);
          first = 0;
        end
        chk(sum == q[0].s, "R1/R2/R9 sum", sum, q[0].s);
        chk(cout == q[0].c, "R1/R2 cout", cout, q[0].c);
        chk(carries == q[0].cy, "R5 carries", carries, q[0].cy);
        chk(ovf == q[0].v, "R6 ovf", ovf, q[0].v);
        chk(in_ready == 0, "R3 in_ready while result pending", in_ready, 0);
      end
      rr++;
      out_ready = (bp == 0) ? 1'b1 : (rr % 3 == 0);
      @(posedge clk);
      if (out_valid && out_ready && ce && q.size() > 0) begin
        void'(q.pop_front());
        first = 1;
      end
    end
  end

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    wait (cyc > 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    clr = 0;
    chk(in_ready == 1, "R8 reset in_ready", in_ready, 1);
    chk(out_valid == 0, "R8 reset out_valid", out_valid, 0);
    // R1 R9 additions incl. slice-crossing carries
    send(20'h00000, 20'h00000, 0);
    send(20'h000FF, 20'h00001, 0);
    send(20'h0FFFF, 20'h00001, 0);
    send(20'hFFFFF, 20'h00001, 0);
    send(20'h7FFFF, 20'h00001, 0);
    send(20'h80000, 20'h80000, 0);
    send(20'h3A5C1, 20'h4D27E, 0);
    // R2 subtractions
    send(20'h00005, 20'h00003, 1);
    send(20'h00003, 20'h00005, 1);
    send(20'h80000, 20'h00001, 1);
    send(20'h00000, 20'h00000, 1);
    send(20'h12345, 20'hFEDCB, 1);
    drain();
    // R4 backpressure
    bp = 1;
    for (int i = 0; i < 6; i++) send(20'(i * 20'h2F1B3), 20'(20'hFFFFF - i * 20'h1357), i[0]);
    drain();
    bp = 0;
    // R7 stall mid-computation and while result waits
    send(20'h0FFFF, 20'h0FFFF, 0);
    ce = 0;
    repeat (5) @(negedge clk);
    chk(out_valid == 0, "R7 frozen mid-run", out_valid, 0);
    ce = 1;
    drain();
    bp = 2;
    send(20'hABCDE, 20'h12345, 1);
    repeat (NS) @(negedge clk);
    ce = 0;
    bp = 0;
    repeat (4) @(negedge clk);
    chk(out_valid == 1, "R7 no handshake while disabled", out_valid, 1);
    ce = 1;
    drain();
    // R8 clear during run with ce low
    @(negedge clk);
    a = 20'h11111; b = 20'h22222; op_sub = 0; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    ce = 0; clr = 1;
    @(negedge clk);
    clr = 0;
    chk(in_ready == 1, "R8 clear in_ready", in_ready, 1);
    chk(out_valid == 0, "R8 clear out_valid", out_valid, 0);
    ce = 1;
    repeat (NS + 3) @(negedge clk);
    chk(out_valid == 0, "R8 dropped operation", out_valid, 0);
    send(20'h00001, 20'h00002, 0);
    drain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule